// File: doc/BRIEF.md
# Phase-Centering Window Control

This block supervises the relative phase between a serial-side frame reference and two parallel-side frame references: a receive path and a transmit path. For each path it measures how many clocks separate the parallel frame pulse from the most recent serial frame pulse. It keeps a registered alignment phase and compares the new measurement against that phase. When the difference goes past a tolerance window, and automatic alignment is on, the block snaps the phase to the new measurement. It then pulses an event output and latches a sticky interrupt flag.

Software can request centering by writing a control bit. While the bit is set, the tolerance shrinks from a wide window to a narrow one, so small drifts also trigger realignment and the phase is pulled to the current measured offset. The bit clears itself after a fixed number of serial frames, and software may clear it earlier. While the bit is set, writes to the connection memories are blocked through a gate output. A set request is refused while a memory block fill is in progress.

Top module: `phase_center_ctl`

## Requirements
- R1: After reset, align_evt, align_phase, irq and mem_wr_lock are all zero, and the control (address 0), status (address 1) and mask (address 2) registers read as zero.
- R2: The measured offset k is the number of clocks from the cycle in which ser_fp rises to the cycle in which a par_fp bit rises. It is taken as +k when k is at most FRAME_LEN/2, and as k-FRAME_LEN otherwise.
- R3: When automatic alignment is on (control bit 0), a rise of par_fp[c] whose offset differs from channel c's phase by more than the window makes align_phase slice c equal to the offset. align_evt[c] is high for exactly the following cycle. Channel 0 is receive and channel 1 is transmit, and each phase slice is OFS_W bits in two's complement.
- R4: A difference whose magnitude equals the window, or is smaller, leaves the phase unchanged and raises no event.
- R5: The window is WIDE_WIN (4) while centering is off and NARROW_WIN (1) while centering (control bit 1) is on.
- R6: With control bit 0 clear, no event is raised and no phase changes, whatever the offsets.
- R7: Writing control bit 1 as 1 starts centering. Centering ends by itself on the CENTER_FRAMES-th (8th) following rise of ser_fp. Writing control bit 1 as 0 ends it at once.
- R8: A centering start request written while fill_busy is high is ignored.
- R9: mem_wr_lock is high exactly while centering is on, and cm_wr_ok equals cm_wr_req while centering is off and is low while centering is on.
- R10: Status bit c (address 1; bit 0 receive, bit 1 transmit) is set in the cycle after align_evt[c] and stays set. Writing 1 to a bit clears it, and writing 0 leaves it as it is.
- R11: irq is high when any status bit is set whose mask bit (address 2, 1 = enabled, same bit positions) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_fp | input | 1 | Serial-side frame pulse |
| par_fp | input | 2 | Parallel-side frame pulses (bit 0 receive, bit 1 transmit) |
| fill_busy | input | 1 | A memory block fill is running |
| cm_wr_req | input | 1 | Connection-memory write request from the CPU side |
| cm_wr_ok | output | 1 | Gated connection-memory write enable |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data (combinational) |
| align_evt | output | 2 | One-cycle realignment event per channel |
| align_phase | output | 2*OFS_W | Current alignment phase per channel, signed |
| mem_wr_lock | output | 1 | Centering active; memory writes locked |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: a 64-clock frame, windows of 4 and 1, and an 8-frame centering period. The short frame keeps each measurement to a few dozen cycles, so one run covers offsets on both sides of the half-frame fold, including +32 and the wrap of 33 to -31. It also covers the exact window edge in both directions and the full eight-frame expiry count. Because the window values are small, the boundary and one-past-boundary cases can be reached with plain pulse spacing.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
   localparam int NUM_CH = 2;
   localparam int CH_RX  = 0;
   localparam int CH_TX  = 1;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_MASK = 2'd2;

   localparam int CTRL_AUTO_BIT   = 0;
   localparam int CTRL_CENTER_BIT = 1;
endpackage

// File: rtl/pcw_ref_timer.sv
// Counts clocks since the last serial frame rise; reports the phase seen now.
module pcw_ref_timer #(
   parameter  int FRAME_LEN = 64,
   localparam int CNT_W     = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_fp,
   output logic             ser_rise,
   output logic [CNT_W-1:0] ref_phase
);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FRAME_LEN - 1);

   logic             fp_q;
   logic [CNT_W-1:0] cnt;

   assign ser_rise  = ser_fp & ~fp_q;
   assign ref_phase = ser_rise ? '0 : cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fp_q <= 1'b0;
         cnt  <= '0;
      end else begin
         fp_q <= ser_fp;
         if (ser_rise)
            cnt <= CNT_W'(1);
         else if (cnt != CNT_TOP)
            cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/pcw_align_chan.sv
// One alignment channel: folds the measured offset, compares with the window,
// and snaps the held phase when the window is exceeded.
module pcw_align_chan #(
   parameter  int FRAME_LEN  = 64,
   parameter  int WIDE_WIN   = 4,
   parameter  int NARROW_WIN = 1,
   localparam int CNT_W      = $clog2(FRAME_LEN),
   localparam int OFS_W      = CNT_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    par_fp,
   input  logic                    auto_en,
   input  logic                    narrow,
   input  logic [CNT_W-1:0]        ref_phase,
   output logic                    evt,
   output logic signed [OFS_W-1:0] adj
);
   localparam logic [CNT_W-1:0]        HALF     = CNT_W'(FRAME_LEN / 2);
   localparam logic [OFS_W-1:0]        FLEN     = OFS_W'(FRAME_LEN);
   localparam logic signed [OFS_W:0]   WIDE_S   = (OFS_W+1)'(WIDE_WIN);
   localparam logic signed [OFS_W:0]   NARROW_S = (OFS_W+1)'(NARROW_WIN);

   logic                    par_q;
   logic                    par_rise;
   logic [OFS_W-1:0]        ph_ext;
   logic signed [OFS_W-1:0] raw;
   logic signed [OFS_W:0]   resid;
   logic signed [OFS_W:0]   win;
   logic                    outside;
   logic                    realign;

   assign par_rise = par_fp & ~par_q;
   assign ph_ext   = {1'b0, ref_phase};
   assign raw      = (ref_phase > HALF) ? $signed(ph_ext - FLEN) : $signed(ph_ext);
   assign resid    = $signed({raw[OFS_W-1], raw}) - $signed({adj[OFS_W-1], adj});
   assign win      = narrow ? NARROW_S : WIDE_S;
   assign outside  = (resid > win) || (resid < -win);
   assign realign  = auto_en & par_rise & outside;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
         adj   <= '0;
         evt   <= 1'b0;
      end else begin
         par_q <= par_fp;
         evt   <= realign;
         if (realign)
            adj <= raw;
      end
   end
endmodule

// File: rtl/pcw_center_timer.sv
// Centering request bit with frame-counted self-clear.
module pcw_center_timer #(
   parameter  int CENTER_FRAMES = 8,
   localparam int FC_W          = $clog2(CENTER_FRAMES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ctrl,
   input  logic wr_center,
   input  logic fill_busy,
   input  logic ser_rise,
   output logic center
);
   localparam logic [FC_W-1:0] LAST = FC_W'(CENTER_FRAMES - 1);

   logic [FC_W-1:0] fcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         center <= 1'b0;
         fcnt   <= '0;
      end else if (wr_ctrl && !wr_center) begin
         center <= 1'b0;
         fcnt   <= '0;
      end else if (wr_ctrl && wr_center && !fill_busy) begin
         center <= 1'b1;
         fcnt   <= '0;
      end else if (center && ser_rise) begin
         if (fcnt == LAST) begin
            center <= 1'b0;
            fcnt   <= '0;
         end else begin
            fcnt <= fcnt + FC_W'(1);
         end
      end
   end
endmodule

// File: rtl/phase_center_ctl.sv
module phase_center_ctl
   import pcw_pkg::*;
#(
   parameter  int FRAME_LEN     = 64,
   parameter  int WIDE_WIN      = 4,
   parameter  int NARROW_WIN    = 1,
   parameter  int CENTER_FRAMES = 8,
   parameter  int DATA_W        = 8,
   localparam int CNT_W         = $clog2(FRAME_LEN),
   localparam int OFS_W         = CNT_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ser_fp,
   input  logic [NUM_CH-1:0]       par_fp,
   input  logic                    fill_busy,
   input  logic                    cm_wr_req,
   output logic                    cm_wr_ok,
   input  logic                    cpu_wr,
   input  logic [1:0]              cpu_addr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   output logic [DATA_W-1:0]       cpu_rdata,
   output logic [NUM_CH-1:0]       align_evt,
   output logic [NUM_CH*OFS_W-1:0] align_phase,
   output logic                    mem_wr_lock,
   output logic                    irq
);
   // elaboration-time parameter checks
   if (FRAME_LEN < 8) begin : g_bad_frame
      $error("FRAME_LEN must be at least 8");
   end
   if (NARROW_WIN < 0 || NARROW_WIN >= WIDE_WIN) begin : g_bad_win
      $error("NARROW_WIN must be non-negative and below WIDE_WIN");
   end
   if (WIDE_WIN >= FRAME_LEN / 2) begin : g_bad_wide
      $error("WIDE_WIN must be below half a frame");
   end
   if (CENTER_FRAMES < 1) begin : g_bad_cf
      $error("CENTER_FRAMES must be at least 1");
   end
   if (DATA_W < NUM_CH + 1) begin : g_bad_dw
      $error("DATA_W too narrow for register fields");
   end

   logic              ser_rise;
   logic [CNT_W-1:0]  ref_phase;
   logic              center;
   logic              auto_en;
   logic [NUM_CH-1:0] irq_stat;
   logic [NUM_CH-1:0] irq_mask;
   logic              wr_ctrl;
   logic              wr_stat;
   logic              wr_mask;
   logic              unused_wdata;

   assign wr_ctrl      = cpu_wr && (cpu_addr == ADDR_CTRL);
   assign wr_stat      = cpu_wr && (cpu_addr == ADDR_STAT);
   assign wr_mask      = cpu_wr && (cpu_addr == ADDR_MASK);
   assign unused_wdata = ^cpu_wdata[DATA_W-1:NUM_CH];

   pcw_ref_timer #(.FRAME_LEN(FRAME_LEN)) u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_fp    (ser_fp),
      .ser_rise  (ser_rise),
      .ref_phase (ref_phase)
   );

   pcw_center_timer #(.CENTER_FRAMES(CENTER_FRAMES)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .wr_center (cpu_wdata[CTRL_CENTER_BIT]),
      .fill_busy (fill_busy),
      .ser_rise  (ser_rise),
      .center    (center)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pcw_align_chan #(
         .FRAME_LEN  (FRAME_LEN),
         .WIDE_WIN   (WIDE_WIN),
         .NARROW_WIN (NARROW_WIN)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .par_fp    (par_fp[c]),
         .auto_en   (auto_en),
         .narrow    (center),
         .ref_phase (ref_phase),
         .evt       (align_evt[c]),
         .adj       (align_phase[c*OFS_W +: OFS_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_en  <= 1'b0;
         irq_mask <= '0;
         irq_stat <= '0;
      end else begin
         if (wr_ctrl)
            auto_en <= cpu_wdata[CTRL_AUTO_BIT];
         if (wr_mask)
            irq_mask <= cpu_wdata[NUM_CH-1:0];
         // set has priority over a same-cycle clear
         irq_stat <= (irq_stat & ~(wr_stat ? cpu_wdata[NUM_CH-1:0] : '0)) | align_evt;
      end
   end

   always_comb begin
      cpu_rdata = '0;
      case (cpu_addr)
         ADDR_CTRL: begin
            cpu_rdata[CTRL_AUTO_BIT]   = auto_en;
            cpu_rdata[CTRL_CENTER_BIT] = center;
         end
         ADDR_STAT: cpu_rdata[NUM_CH-1:0] = irq_stat;
         ADDR_MASK: cpu_rdata[NUM_CH-1:0] = irq_mask;
         default:   cpu_rdata = '0;
      endcase
   end

   assign mem_wr_lock = center;
   assign cm_wr_ok    = cm_wr_req & ~center;
   assign irq         = |(irq_stat & irq_mask);
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker
   import pcw_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr,
   input logic [1:0]        cpu_addr,
   input logic              wd_center,
   input logic              fill_busy,
   input logic              ser_rise,
   input logic              center,
   input logic              auto_en,
   input logic [NUM_CH-1:0] stat,
   input logic [NUM_CH-1:0] align_evt,
   input logic              cm_wr_ok
);
   p_evt_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (align_evt != '0) |=> ((stat & $past(align_evt)) == $past(align_evt)));

   p_no_evt_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> (align_evt == '0));

   p_evt_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (align_evt != '0) |=> ((align_evt & $past(align_evt)) == '0));

   p_center_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(center) |-> $past(cpu_wr && (cpu_addr == ADDR_CTRL) && wd_center));

   p_center_no_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(center) |-> !$past(fill_busy));

   p_center_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(center) |-> ($past(cpu_wr && (cpu_addr == ADDR_CTRL)) || $past(ser_rise)));

   p_lock_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      center |-> !cm_wr_ok);
endmodule

bind phase_center_ctl pcw_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_wr    (cpu_wr),
   .cpu_addr  (cpu_addr),
   .wd_center (cpu_wdata[1]),
   .fill_busy (fill_busy),
   .ser_rise  (ser_rise),
   .center    (center),
   .auto_en   (auto_en),
   .stat      (irq_stat),
   .align_evt (align_evt),
   .cm_wr_ok  (cm_wr_ok)
);

// File: tb/sim_phase_center_ctl.sv
`timescale 1ns/1ps
module sim_phase_center_ctl;
   localparam int FRAME_LEN = 64;
   localparam int OFS_W     = $clog2(FRAME_LEN) + 1;
   localparam int DATA_W    = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ser_fp = 1'b0;
   logic [1:0]        par_fp = '0;
   logic              fill_busy = 1'b0;
   logic              cm_wr_req = 1'b0;
   logic              cm_wr_ok;
   logic              cpu_wr = 1'b0;
   logic [1:0]        cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [DATA_W-1:0] cpu_rdata;
   logic [1:0]        align_evt;
   logic [2*OFS_W-1:0] align_phase;
   logic              mem_wr_lock;
   logic              irq;

   int checks = 0;
   int errors = 0;
   int evt_s;
   int ph_s;

   always #2.5 clk = ~clk;

   phase_center_ctl #(.FRAME_LEN(FRAME_LEN)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_fp(ser_fp), .par_fp(par_fp),
      .fill_busy(fill_busy), .cm_wr_req(cm_wr_req), .cm_wr_ok(cm_wr_ok),
      .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .align_evt(align_evt), .align_phase(align_phase),
      .mem_wr_lock(mem_wr_lock), .irq(irq)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int phase_of(int ch);
      logic [OFS_W-1:0] s;
      s = align_phase[ch*OFS_W +: OFS_W];
      return int'($signed(s));
   endfunction

   task automatic wr(logic [1:0] a, int d);
      cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = DATA_W'(d);
      @(negedge clk);
      cpu_wr = 1'b0; cpu_wdata = '0;
   endtask

   task automatic rd(logic [1:0] a, output int d);
      cpu_addr = a;
      #1;
      d = int'(cpu_rdata);
   endtask

   // serial pulse, then parallel pulse on channel ch k clocks later
   task automatic meas(int ch, int k);
      if (k == 0) begin
         ser_fp = 1'b1; par_fp[ch] = 1'b1;
         @(negedge clk);
         ser_fp = 1'b0; par_fp[ch] = 1'b0;
      end else begin
         ser_fp = 1'b1;
         @(negedge clk);
         ser_fp = 1'b0;
         repeat (k - 1) @(negedge clk);
         par_fp[ch] = 1'b1;
         @(negedge clk);
         par_fp[ch] = 1'b0;
      end
      evt_s = int'(align_evt);
      ph_s  = phase_of(ch);
      @(negedge clk);
   endtask

   task automatic ser_pulse();
      ser_fp = 1'b1;
      @(negedge clk);
      ser_fp = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      int d;
      chk("R1", "align_evt", int'(align_evt), 0);
      chk("R1", "align_phase", int'(align_phase), 0);
      chk("R1", "irq", int'(irq), 0);
      chk("R1", "mem_wr_lock", int'(mem_wr_lock), 0);
      rd(2'd0, d); chk("R1", "ctrl", d, 0);
      rd(2'd1, d); chk("R1", "stat", d, 0);
      rd(2'd2, d); chk("R1", "mask", d, 0);
   endtask

   task automatic t_disabled();
      meas(0, 10);
      chk("R6", "evt with auto off", evt_s, 0);
      chk("R6", "phase with auto off", ph_s, 0);
   endtask

   task automatic t_realign();
      int d;
      wr(2'd0, 1);
      meas(0, 10);
      chk("R3", "evt rx", evt_s, 1);
      chk("R2", "phase after +10", ph_s, 10);
      rd(2'd1, d); chk("R10", "stat rx set", d, 1);
   endtask

   task automatic t_window();
      meas(0, 14);
      chk("R4", "evt at +4 edge", evt_s, 0);
      chk("R5", "phase kept at +4 edge", ph_s, 10);
      meas(0, 5);
      chk("R5", "evt at -5", evt_s, 1);
      chk("R3", "phase after -5", ph_s, 5);
   endtask

   task automatic t_wrap();
      meas(0, 33);
      chk("R2", "phase at 33 folds", ph_s, -31);
      meas(0, 32);
      chk("R2", "phase at half frame", ph_s, 32);
      meas(0, 60);
      chk("R2", "phase at 60 folds", ph_s, -4);
      meas(0, 0);
      chk("R4", "evt at -4 edge", evt_s, 0);
      chk("R4", "phase kept at -4 edge", ph_s, -4);
      meas(0, 2);
      chk("R3", "phase after +6", ph_s, 2);
   endtask

   task automatic t_narrow();
      int d;
      wr(2'd0, 3);
      chk("R9", "lock on", int'(mem_wr_lock), 1);
      rd(2'd0, d); chk("R7", "ctrl with center", d, 3);
      meas(0, 3);
      chk("R5", "narrow +1 no evt", evt_s, 0);
      meas(0, 4);
      chk("R5", "narrow +2 evt", evt_s, 1);
      chk("R5", "narrow phase", ph_s, 4);
      wr(2'd0, 1);
      chk("R7", "early clear", int'(mem_wr_lock), 0);
      cm_wr_req = 1'b1; #1;
      chk("R9", "write passes", int'(cm_wr_ok), 1);
      cm_wr_req = 1'b0;
   endtask

   task automatic t_expiry();
      wr(2'd0, 3);
      cm_wr_req = 1'b1; #1;
      chk("R9", "write blocked", int'(cm_wr_ok), 0);
      cm_wr_req = 1'b0;
      for (int i = 0; i < 7; i++) ser_pulse();
      chk("R7", "center after 7 frames", int'(mem_wr_lock), 1);
      ser_pulse();
      chk("R7", "center after 8 frames", int'(mem_wr_lock), 0);
   endtask

   task automatic t_fill();
      int d;
      fill_busy = 1'b1;
      wr(2'd0, 3);
      rd(2'd0, d); chk("R8", "set refused during fill", d, 1);
      chk("R8", "no lock during fill", int'(mem_wr_lock), 0);
      fill_busy = 1'b0;
   endtask

   task automatic t_irq();
      int d;
      chk("R11", "irq masked", int'(irq), 0);
      wr(2'd2, 1);
      chk("R11", "irq enabled", int'(irq), 1);
      wr(2'd1, 0);
      rd(2'd1, d); chk("R10", "write 0 keeps", d, 1);
      wr(2'd1, 1);
      rd(2'd1, d); chk("R10", "write 1 clears", d, 0);
      chk("R11", "irq after clear", int'(irq), 0);
   endtask

   task automatic t_tx();
      int d;
      meas(1, 20);
      chk("R3", "evt tx", evt_s, 2);
      chk("R3", "tx phase", ph_s, 20);
      chk("R3", "rx phase untouched", phase_of(0), 4);
      rd(2'd1, d); chk("R10", "stat tx", d, 2);
      chk("R11", "tx masked", int'(irq), 0);
      wr(2'd2, 2);
      chk("R11", "tx enabled", int'(irq), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_realign();
      t_window();
      t_wrap();
      t_narrow();
      t_expiry();
      t_fill();
      t_irq();
      t_tx();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule